// File: doc/BRIEF.md
# Page-Mode DRAM Burst Controller

This controller sits between a requester and a DRAM whose row and column addresses share one set of address pins. For each accepted request it opens a row by driving the row half of the address with the row strobe low. It then streams four column addresses with column strobes while the row stays open, so that four words move in one burst. A request carries a read/write flag, a start address and a two-bit timing selector. The selector fixes the spacing between column strobes for the whole burst. The first word always costs `FIRST_CYC` cycles. Each later word costs three, two or one cycles, which matches page-mode, buffered-output and synchronous parts.

The state machine has four states. In `ST_IDLE` both strobes are high and the block waits for a request. In `ST_ROW` the row is on the pins with the row strobe low. `ST_CWAIT` holds the next column address with the column strobe high. `ST_CSTB` is the single cycle in which the column strobe is low and a word moves. The transitions are as follows:
- IDLE→ROW when a request is accepted.
- ROW→CSTB after `FIRST_CYC-1` cycles.
- CSTB→CWAIT between words when the gap is 2 or 3.
- CSTB→CSTB between words when the gap is 1.
- CWAIT→CSTB after gap−1 cycles.
- CSTB→IDLE after the fourth word.

A refresh-busy input blocks acceptance. A pending request waits until refresh ends. The refresh scheduler is expected to raise it only between bursts, because it does not stop a burst that has already started.

Top module: `pagemode_burst_ctrl`

## Requirements
- R1: During and right after reset, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are 1, `rd_valid` and `wr_take` are 0, and `mem_addr` and `mem_dout` are 0.
- R2: `req_ready` is 1 exactly when no burst is in progress and `refresh_busy` is 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: Counting the cycle after the accepting edge as cycle 1, `mem_ras_n` is 0 in cycles 1 through `FIRST_CYC+3g`, where g is the word gap. In cycles 1 to `FIRST_CYC-1`, `mem_addr` carries the row field, which is `req_addr[ROW_W+COL_W-1:COL_W]`.
- R4: `mem_cas_n` is 0 exactly in cycles `FIRST_CYC+k*g` for k = 0..3, and is 1 in every other cycle.
- R5: The gap g comes from `req_mode`: 00 gives 3, 01 gives 2, 10 gives 1, and 11 gives 3.
- R6: From cycle `FIRST_CYC` on, `mem_addr` carries word k's column from the first cycle of its slot, zero-extended. The column keeps the start column (`req_addr[COL_W-1:0]`) above bit 1, and its two low bits are (start + k) mod 4.
- R7: In a read burst, `mem_din` is sampled in each column-strobe cycle and appears on `rd_data` with `rd_valid` high in the next cycle. `rd_last` is high only with the fourth word.
- R8: In a write burst, `mem_we_n` is 0 and `wr_take` is 1 exactly in the column-strobe cycles, and `mem_dout` equals `wr_data` in those cycles. Otherwise `mem_we_n` is 1 and `mem_dout` is 0.
- R9: The gap, address and direction are captured at acceptance. Changes to `req_mode`, `req_addr` or `req_write` during a burst have no effect on it.
- R10: After the fourth strobe the row strobe rises and the block is idle. Every accepted request, including one taken in the first idle cycle after a burst, starts with a fresh row phase.
- R11: While `refresh_busy` is 1, no request is accepted. A waiting request is accepted on the first edge after `refresh_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ROW_W+COL_W | Start address, row field above column field |
| req_mode | input | 2 | Word-gap selector |
| wr_data | input | DATA_W | Write word currently offered |
| wr_take | output | 1 | Current write word is consumed this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Fourth word of the burst |
| refresh_busy | input | 1 | Refresh in progress; blocks acceptance |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | DATA_W | Write data to DRAM |
| mem_din | input | DATA_W | Read data from DRAM |

## Verification
The bench targets start columns at offsets 2 and 3 of a four-word block and the all-ones column. A controller that carries into the upper column bits would present addresses outside the block there. The bench runs every gap code, including the reserved one, and issues requests back to back, so an off-by-one slot length shows up as a column strobe a cycle early or late, and a missed row reopen shows up as a strobe without a row phase. It scrambles the request fields right after acceptance, which catches a controller that reads the selector live. A request waiting behind refresh checks that acceptance neither leaks through nor lags once refresh ends.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROW   = 2'd1,
        ST_CWAIT = 2'd2,
        ST_CSTB  = 2'd3
    } pmb_state_e;

    // Cycles per word after the first one, selected per burst.
    function automatic logic [1:0] word_gap(input logic [1:0] sel);
        case (sel)
            2'd1:    return 2'd2;
            2'd2:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pmb_fsm.sv
module pmb_fsm
    import pmb_pkg::*;
#(
    parameter int FIRST_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] gap_in,
    output pmb_state_e state,
    output logic [1:0] beat
);
    localparam int CNT_W = $clog2(FIRST_CYC + 1);

    pmb_state_e       state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]       beat_n, gap, gap_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            beat  <= '0;
            gap   <= 2'd3;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            beat  <= beat_n;
            gap   <= gap_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        beat_n  = beat;
        gap_n   = gap;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_ROW;
                    cnt_n   = '0;
                    beat_n  = '0;
                    gap_n   = gap_in;
                end
            end
            ST_ROW: begin
                if (cnt == CNT_W'(FIRST_CYC - 2)) begin
                    state_n = ST_CSTB;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_CSTB: begin
                if (beat == 2'd3) begin
                    state_n = ST_IDLE;
                end else begin
                    beat_n  = beat + 1'b1;
                    cnt_n   = '0;
                    state_n = (gap == 2'd1) ? ST_CSTB : ST_CWAIT;
                end
            end
            ST_CWAIT: begin
                if (cnt == CNT_W'(gap) - CNT_W'(2)) begin
                    state_n = ST_CSTB;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pmb_addr_mux.sv
module pmb_addr_mux
    import pmb_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8,
    parameter int MA_W  = 10
) (
    input  pmb_state_e       state,
    input  logic [1:0]       beat,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col_base,
    output logic [MA_W-1:0]  mem_addr
);
    logic [COL_W-1:0] col_word;

    // Wrap inside the aligned four-word block.
    always_comb begin
        col_word = (col_base & ~COL_W'(3)) | ((col_base + COL_W'(beat)) & COL_W'(3));
        unique case (state)
            ST_IDLE:           mem_addr = '0;
            ST_ROW:            mem_addr = MA_W'(row);
            ST_CWAIT, ST_CSTB: mem_addr = MA_W'(col_word);
            default:           mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/pmb_rd_capture.sv
module pmb_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              last,
    input  logic [DATA_W-1:0] din,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            rd_last  <= take && last;
            if (take) rd_data <= din;
        end
    end

endmodule

// File: rtl/pagemode_burst_ctrl.sv
module pagemode_burst_ctrl
    import pmb_pkg::*;
#(
    parameter  int ROW_W     = 10,
    parameter  int COL_W     = 8,
    parameter  int DATA_W    = 16,
    parameter  int FIRST_CYC = 5,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    input  logic              refresh_busy,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din
);
    pmb_state_e       state;
    logic [1:0]       beat;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             wr_q;
    logic             accept;
    logic             strobe;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            row_q <= req_addr[ADDR_W-1:COL_W];
            col_q <= req_addr[COL_W-1:0];
            wr_q  <= req_write;
        end
    end

    pmb_fsm #(.FIRST_CYC(FIRST_CYC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .gap_in (word_gap(req_mode)),
        .state  (state),
        .beat   (beat)
    );

    pmb_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_addr (
        .state    (state),
        .beat     (beat),
        .row      (row_q),
        .col_base (col_q),
        .mem_addr (mem_addr)
    );

    pmb_rd_capture #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (strobe && !wr_q),
        .last     (beat == 2'd3),
        .din      (mem_din),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_last  (rd_last)
    );

    always_comb begin
        strobe    = (state == ST_CSTB);
        req_ready = (state == ST_IDLE) && !refresh_busy;
        mem_ras_n = (state == ST_IDLE);
        mem_cas_n = !strobe;
        mem_we_n  = !(strobe && wr_q);
        wr_take   = strobe && wr_q;
        mem_dout  = (strobe && wr_q) ? wr_data : '0;
    end

endmodule

// File: rtl/pmb_checker.sv
module pmb_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic refresh_busy,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic rd_valid,
    input logic rd_last
);
    logic [2:0] cas_seen;

    always_ff @(posedge clk) begin
        if (!rst_n || mem_ras_n) cas_seen <= '0;
        else if (!mem_cas_n)     cas_seen <= cas_seen + 1'b1;
    end

    a_r4_cas_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);

    a_r11_no_start_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> !req_ready);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ras_n);

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    a_r7_valid_after_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_cas_n && mem_we_n));

    a_r8_we_needs_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cas_n);

    a_r10_four_words_per_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n) |-> (cas_seen == 3'd4));

    a_r10_no_fifth_word: assert property (@(posedge clk) disable iff (!rst_n)
        cas_seen <= 3'd4);

endmodule

bind pagemode_burst_ctrl pmb_checker u_pmb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .refresh_busy (refresh_busy),
    .mem_ras_n    (mem_ras_n),
    .mem_cas_n    (mem_cas_n),
    .mem_we_n     (mem_we_n),
    .rd_valid     (rd_valid),
    .rd_last      (rd_last)
);

// File: tb/tb_pagemode_burst_ctrl.sv
module tb_pagemode_burst_ctrl;
    localparam int ROW_W = 10;
    localparam int COL_W = 8;
    localparam int DATA_W = 16;
    localparam int X = 5;
    localparam int AW = ROW_W + COL_W;
    localparam int MA_W = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [1:0]        req_mode = 2'd0;
    logic [DATA_W-1:0] wr_data;
    logic              wr_take;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rd_last;
    logic              refresh_busy = 1'b0;
    logic [MA_W-1:0]   mem_addr;
    logic              mem_ras_n, mem_cas_n, mem_we_n;
    logic [DATA_W-1:0] mem_dout;
    logic [DATA_W-1:0] mem_din;

    pagemode_burst_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .FIRST_CYC(X)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_mode(req_mode),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .refresh_busy(refresh_busy), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_din(mem_din)
    );

    int checks = 0;
    int errors = 0;
    string scen = "R1";

    // Reference model state
    int            tcnt = 1000;
    int            m_y = 3;
    logic [9:0]    m_row = '0;
    logic [7:0]    m_col = '0;
    bit            m_wr = 1'b0;
    logic [15:0]   wbase_req = '0;
    logic [15:0]   wbase_q = '0;
    int            wr_idx = 0;
    bit            acc_flag = 1'b0;
    logic [9:0]    cur_row = '0;
    logic          prev_ras = 1'b1;

    function automatic int gap_of(input logic [1:0] m);
        if (m == 2'd1) return 2;
        if (m == 2'd2) return 1;
        return 3;
    endfunction

    function automatic logic [7:0] col_of(input logic [7:0] c, input int k);
        return (c & 8'hFC) | ((c + 8'(k)) & 8'h03);
    endfunction

    function automatic logic [15:0] dval(input logic [9:0] r, input logic [9:0] c);
        return (16'(r) * 16'd37) ^ (16'(c) * 16'd11) ^ 16'h5A5A;
    endfunction

    assign mem_din = dval(cur_row, mem_addr);
    assign wr_data = wbase_q + 16'(wr_idx);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin : monitor
        int         endt, k, kr;
        bit         busy, cas_e, rdv_e;
        logic [9:0] addr_e;
        string      t1;
        tcnt++;
        endt   = X + 3 * m_y;
        busy   = (tcnt >= 1) && (tcnt <= endt);
        cas_e  = 1'b0;
        k      = 0;
        addr_e = '0;
        if (busy) begin
            if (tcnt < X) begin
                addr_e = m_row;
            end else begin
                k      = (tcnt - X + m_y - 1) / m_y;
                cas_e  = ((tcnt - X) % m_y) == 0;
                addr_e = 10'(col_of(m_col, k));
            end
        end
        rdv_e = 1'b0;
        kr    = 0;
        if (!m_wr)
            for (int j = 0; j < 4; j++)
                if (tcnt == X + j * m_y + 1) begin rdv_e = 1'b1; kr = j; end

        t1 = rst_n ? "" : "R1";
        chk(rst_n ? "R2"  : t1, "req_ready", 32'(req_ready), 32'(!busy && !refresh_busy));
        chk(rst_n ? "R3"  : t1, "ras_n",     32'(mem_ras_n), 32'(!busy));
        chk(rst_n ? "R4"  : t1, "cas_n",     32'(mem_cas_n), 32'(!cas_e));
        chk(rst_n ? "R6"  : t1, "mem_addr",  32'(mem_addr),  32'(addr_e));
        chk(rst_n ? "R8"  : t1, "we_n",      32'(mem_we_n),  32'(!(cas_e && m_wr)));
        chk(rst_n ? "R8"  : t1, "wr_take",   32'(wr_take),   32'(cas_e && m_wr));
        chk(rst_n ? "R8"  : t1, "mem_dout",  32'(mem_dout),
            (cas_e && m_wr) ? 32'(wbase_q + 16'(k)) : 32'd0);
        chk(rst_n ? "R7"  : t1, "rd_valid",  32'(rd_valid),  32'(rdv_e));
        chk(rst_n ? "R7"  : t1, "rd_last",   32'(rd_last),   32'(rdv_e && kr == 3));
        if (rdv_e)
            chk("R7", "rd_data", 32'(rd_data), 32'(dval(m_row, 10'(col_of(m_col, kr)))));

        // Bench-side DRAM: row latched when the row strobe falls.
        if (prev_ras && !mem_ras_n) cur_row = mem_addr;
        prev_ras = mem_ras_n;
        if (wr_take) wr_idx++;

        if (req_valid && req_ready) begin
            m_row    = req_addr[AW-1:COL_W];
            m_col    = req_addr[COL_W-1:0];
            m_wr     = req_write;
            m_y      = gap_of(req_mode);
            wbase_q  = wbase_req;
            wr_idx   = 0;
            tcnt     = 0;
            acc_flag = 1'b1;
        end
    end

    task automatic issue(input bit wr, input logic [9:0] row, input logic [7:0] col,
                         input logic [1:0] m, input logic [15:0] wb, input string tag);
        @(posedge clk);
        #1;
        scen      = tag;
        acc_flag  = 1'b0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {row, col};
        req_mode  = m;
        wbase_req = wb;
        do @(posedge clk); while (!acc_flag);
        #1;
        // R9: scramble request fields while the burst runs.
        req_valid = 1'b0;
        req_mode  = ~m;
        req_addr  = ~{row, col};
        req_write = ~wr;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R5/R6: page profile, start at offset 2 of its block -> 3E,3F,3C,3D
        issue(1'b0, 10'h155, 8'h3E, 2'b00, 16'h0000, "R5");
        // R8: buffered-output write, back to back (R10)
        issue(1'b1, 10'h2A3, 8'h10, 2'b01, 16'h1000, "R8");
        // R9: synchronous read, fields scrambled after acceptance; all-ones column
        issue(1'b0, 10'h001, 8'hFF, 2'b10, 16'h0000, "R9");
        issue(1'b1, 10'h3FF, 8'h81, 2'b10, 16'hBEE0, "R10");
        // R5: reserved code behaves like page profile
        issue(1'b0, 10'h0F0, 8'h42, 2'b11, 16'h0000, "R5");
        repeat (25) @(posedge clk);
        // R11: request waits behind refresh
        #1 refresh_busy = 1'b1;
        fork
            begin
                repeat (7) @(posedge clk);
                #1 refresh_busy = 1'b0;
            end
        join_none
        issue(1'b0, 10'h077, 8'h05, 2'b01, 16'h0000, "R11");
        issue(1'b1, 10'h200, 8'h03, 2'b00, 16'h7770, "R10");
        repeat (25) @(posedge clk);
        finish_run();
    end

endmodule